// File: doc/BRIEF.md
# Stuck-At Fault Information Cache

This block is a small direct-mapped cache that remembers which memory blocks are known to contain stuck-at cells. It holds data about faults, not data. For each tracked block it stores up to `NUM_PTRS` failing bit positions, the value each failing cell is stuck at, and a mask that marks which of those pointer slots are in use. Before the first write to a block, a write controller looks up the block address. On a hit it gets the fault positions and stuck values, so it can choose group inversion right away and avoid a second write. On a miss all fault fields are zero, and the controller falls back to write, verify and invert.

The storage is split into `NUM_BANKS` banks of `SETS` entries each, 1024 entries with the default values. The lowest address bits select the bank, the next bits select the entry inside the bank, and the remaining upper bits form the stored tag. When the verify step finds a new fault, the controller writes the full fault record through the update port, and that record overwrites whatever the indexed slot held. An update whose mask is all zero empties the slot instead. Every lookup answers exactly one cycle after it is presented.

Top module: `fic_cache`

## Requirements
- R1: After reset every slot is empty: `rsp_valid_o` and `rsp_hit_o` are low, and any later lookup of a block that was never written misses.
- R2: `rsp_valid_o` is high in exactly the cycle after a cycle with `lk_valid_i` high, and low otherwise.
- R3: The address fields with the default parameters are: bank = addr[3:0], index = addr[9:4], tag = addr[31:10]. Two addresses that differ in any tag bit do not hit on each other's entry.
- R4: A lookup hits only when the slot chosen by bank and index is occupied and its stored tag equals the lookup tag. A hit returns the stored mask, pointers and stuck values.
- R5: A response that is a miss has `rsp_hit_o` low and `rsp_mask_o`, `rsp_ptr_o` and `rsp_val_o` all zero.
- R6: An update with a nonzero mask overwrites the indexed slot whatever it held before. The block that was displaced misses from then on.
- R7: An update with an all-zero mask empties the indexed slot, so a later lookup of that block misses.
- R8: When a lookup and an update address the same slot in the same cycle, the response reflects the slot contents from before that update.
- R9: Slots that share an index but sit in different banks are independent: each keeps its own record.
- R10: Fault slot k uses `rsp_ptr_o[k*PTR_W +: PTR_W]` for its bit position, `rsp_val_o[k]` for its stuck value and `rsp_mask_o[k]` for its in-use flag. The update port uses the same layout, and `PTR_W` is 9 with the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_addr_i | input | ADDR_W | Block address to look up |
| up_valid_i | input | 1 | Update request |
| up_addr_i | input | ADDR_W | Block address to write |
| up_mask_i | input | NUM_PTRS | In-use flags of the fault slots; all zero empties the slot |
| up_ptr_i | input | NUM_PTRS*PTR_W | Failing bit positions |
| up_val_i | input | NUM_PTRS | Stuck values |
| rsp_valid_o | output | 1 | Response valid, one cycle after the lookup |
| rsp_hit_o | output | 1 | Lookup found the block |
| rsp_mask_o | output | NUM_PTRS | In-use flags returned |
| rsp_ptr_o | output | NUM_PTRS*PTR_W | Bit positions returned |
| rsp_val_o | output | NUM_PTRS | Stuck values returned |

## Verification
The hardest case to reach from the ports is a same-cycle collision between a lookup and an update on one slot, because the answer depends on which of the two takes effect first. The stimulus sets up such collisions on purpose, both while the slot holds another tag and while it is being emptied. Direct mapping only shows its conflicts when slots are shared, so the random phase draws addresses from a small pool of tags, indices and banks. That pool makes hits, overwrites of an occupied slot and same-index neighbours in other banks occur often while a behavioural model tracks every slot.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int unsigned FIC_ADDR_W   = 32;
  localparam int unsigned FIC_BANKS    = 16;
  localparam int unsigned FIC_SETS     = 64;
  localparam int unsigned FIC_PTRS     = 4;
  localparam int unsigned FIC_BLK_BITS = 512;
endpackage

// File: rtl/fic_addr_split.sv
module fic_addr_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BANK_W = 4,
  parameter int unsigned IDX_W  = 6,
  localparam int unsigned TAG_W = ADDR_W - BANK_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BANK_W-1:0] bank_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  assign bank_o = addr_i[BANK_W-1:0];
  assign idx_o  = addr_i[BANK_W +: IDX_W];
  assign tag_o  = addr_i[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/fic_bank.sv
module fic_bank #(
  parameter int unsigned SETS  = 64,
  parameter int unsigned TAG_W = 22,
  parameter int unsigned PL_W  = 44,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             wr_keep_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PL_W-1:0]  wr_pl_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_vld_o,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic [PL_W-1:0]  rd_pl_o
);
  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [PL_W-1:0]  pl_q  [SETS];

  // only occupancy needs reset; tag/payload are qualified by it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (wr_en_i) vld_q[wr_idx_i] <= wr_keep_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i] <= wr_tag_i;
      pl_q[wr_idx_i]  <= wr_pl_i;
    end
  end

  assign rd_vld_o = vld_q[rd_idx_i];
  assign rd_tag_o = tag_q[rd_idx_i];
  assign rd_pl_o  = pl_q[rd_idx_i];
endmodule

// File: rtl/fic_resp.sv
module fic_resp #(
  parameter int unsigned TAG_W = 22,
  parameter int unsigned PL_W  = 44
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  logic             sel_vld_i,
  input  logic [TAG_W-1:0] sel_tag_i,
  input  logic [PL_W-1:0]  sel_pl_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [PL_W-1:0]  rsp_pl_o
);
  logic hit_d;
  assign hit_d = lk_valid_i && sel_vld_i && (sel_tag_i == lk_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_pl_o    <= '0;
    end else begin
      rsp_valid_o <= lk_valid_i;
      rsp_hit_o   <= hit_d;
      rsp_pl_o    <= hit_d ? sel_pl_i : '0;
    end
  end
endmodule

// File: rtl/fic_cache.sv
module fic_cache
  import fic_pkg::*;
#(
  parameter int unsigned ADDR_W    = FIC_ADDR_W,
  parameter int unsigned NUM_BANKS = FIC_BANKS,
  parameter int unsigned SETS      = FIC_SETS,
  parameter int unsigned NUM_PTRS  = FIC_PTRS,
  parameter int unsigned BLK_BITS  = FIC_BLK_BITS,
  localparam int unsigned PTR_W    = $clog2(BLK_BITS),
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
  localparam int unsigned IDX_W    = $clog2(SETS),
  localparam int unsigned TAG_W    = ADDR_W - BANK_W - IDX_W,
  localparam int unsigned PL_W     = NUM_PTRS * (PTR_W + 2)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      lk_valid_i,
  input  logic [ADDR_W-1:0]         lk_addr_i,
  input  logic                      up_valid_i,
  input  logic [ADDR_W-1:0]         up_addr_i,
  input  logic [NUM_PTRS-1:0]       up_mask_i,
  input  logic [NUM_PTRS*PTR_W-1:0] up_ptr_i,
  input  logic [NUM_PTRS-1:0]       up_val_i,
  output logic                      rsp_valid_o,
  output logic                      rsp_hit_o,
  output logic [NUM_PTRS-1:0]       rsp_mask_o,
  output logic [NUM_PTRS*PTR_W-1:0] rsp_ptr_o,
  output logic [NUM_PTRS-1:0]       rsp_val_o
);
  logic [BANK_W-1:0] lk_bank, up_bank;
  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;

  fic_addr_split #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_lk_split (
    .addr_i(lk_addr_i), .bank_o(lk_bank), .idx_o(lk_idx), .tag_o(lk_tag)
  );
  fic_addr_split #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_up_split (
    .addr_i(up_addr_i), .bank_o(up_bank), .idx_o(up_idx), .tag_o(up_tag)
  );

  logic [PL_W-1:0] up_pl;
  logic            up_keep;
  assign up_pl   = {up_mask_i, up_val_i, up_ptr_i};
  assign up_keep = |up_mask_i;

  logic             bk_vld [NUM_BANKS];
  logic [TAG_W-1:0] bk_tag [NUM_BANKS];
  logic [PL_W-1:0]  bk_pl  [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic wr_en;
    assign wr_en = up_valid_i && (up_bank == BANK_W'(b));
    fic_bank #(.SETS(SETS), .TAG_W(TAG_W), .PL_W(PL_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en),
      .wr_keep_i(up_keep),
      .wr_idx_i (up_idx),
      .wr_tag_i (up_tag),
      .wr_pl_i  (up_pl),
      .rd_idx_i (lk_idx),
      .rd_vld_o (bk_vld[b]),
      .rd_tag_o (bk_tag[b]),
      .rd_pl_o  (bk_pl[b])
    );
  end

  logic            sel_vld;
  logic [TAG_W-1:0] sel_tag;
  logic [PL_W-1:0]  sel_pl;
  assign sel_vld = bk_vld[lk_bank];
  assign sel_tag = bk_tag[lk_bank];
  assign sel_pl  = bk_pl[lk_bank];

  logic [PL_W-1:0] rsp_pl;
  fic_resp #(.TAG_W(TAG_W), .PL_W(PL_W)) u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_valid_i (lk_valid_i),
    .lk_tag_i   (lk_tag),
    .sel_vld_i  (sel_vld),
    .sel_tag_i  (sel_tag),
    .sel_pl_i   (sel_pl),
    .rsp_valid_o(rsp_valid_o),
    .rsp_hit_o  (rsp_hit_o),
    .rsp_pl_o   (rsp_pl)
  );

  assign {rsp_mask_o, rsp_val_o, rsp_ptr_o} = rsp_pl;
endmodule

// File: rtl/fic_checker.sv
module fic_checker #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NUM_PTRS = 4,
  parameter int unsigned PTR_W    = 9
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      lk_valid_i,
  input logic [ADDR_W-1:0]         lk_addr_i,
  input logic                      up_valid_i,
  input logic [ADDR_W-1:0]         up_addr_i,
  input logic [NUM_PTRS-1:0]       up_mask_i,
  input logic [NUM_PTRS*PTR_W-1:0] up_ptr_i,
  input logic [NUM_PTRS-1:0]       up_val_i,
  input logic                      rsp_valid_o,
  input logic                      rsp_hit_o,
  input logic [NUM_PTRS-1:0]       rsp_mask_o,
  input logic [NUM_PTRS*PTR_W-1:0] rsp_ptr_o,
  input logic [NUM_PTRS-1:0]       rsp_val_o
);
  assert_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> rsp_valid_o);

  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !rsp_valid_o);

  assert_hit_qual_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_valid_o);

  assert_miss_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_hit_o |-> (rsp_mask_o == '0 && rsp_ptr_o == '0 && rsp_val_o == '0));

  assert_fill_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !up_valid_i && $past(up_valid_i) && ($past(up_mask_i) != '0)
     && lk_addr_i == $past(up_addr_i))
    |=> (rsp_hit_o && rsp_mask_o == $past(up_mask_i, 2)
         && rsp_ptr_o == $past(up_ptr_i, 2) && rsp_val_o == $past(up_val_i, 2)));

  assert_clear_miss_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !up_valid_i && $past(up_valid_i) && ($past(up_mask_i) == '0)
     && lk_addr_i == $past(up_addr_i))
    |=> !rsp_hit_o);
endmodule

bind fic_cache fic_checker #(.ADDR_W(ADDR_W), .NUM_PTRS(NUM_PTRS), .PTR_W(PTR_W)) i_fic_checker (.*);

// File: tb/test_fic_cache.sv
module test_fic_cache;
  localparam int AW = 32;
  localparam int NP = 4;
  localparam int PW = 9;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic          lk_valid_i = 1'b0;
  logic [AW-1:0] lk_addr_i = '0;
  logic          up_valid_i = 1'b0;
  logic [AW-1:0] up_addr_i = '0;
  logic [NP-1:0] up_mask_i = '0;
  logic [NP*PW-1:0] up_ptr_i = '0;
  logic [NP-1:0] up_val_i = '0;
  logic          rsp_valid_o, rsp_hit_o;
  logic [NP-1:0] rsp_mask_o, rsp_val_o;
  logic [NP*PW-1:0] rsp_ptr_o;

  always #5 clk_i = ~clk_i;

  fic_cache i_fic_cache (.*);

  int n_chk = 0, n_bad = 0;
  string phase = "R1";

  // behavioural model: slot key addr[9:0], tag addr[31:10]
  logic [21:0]      m_tag  [int];
  logic [NP-1:0]    m_mask [int];
  logic [NP*PW-1:0] m_ptr  [int];
  logic [NP-1:0]    m_val  [int];
  logic             e_v = 0, e_hit = 0;
  logic [NP-1:0]    e_mask = 0, e_val = 0;
  logic [NP*PW-1:0] e_ptr = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_tag.delete(); m_mask.delete(); m_ptr.delete(); m_val.delete();
      e_v = 0; e_hit = 0; e_mask = 0; e_val = 0; e_ptr = 0;
    end else begin
      int k;
      e_v = lk_valid_i; e_hit = 0; e_mask = 0; e_val = 0; e_ptr = 0;
      k = int'(lk_addr_i[9:0]);
      if (lk_valid_i && m_tag.exists(k) && m_tag[k] == lk_addr_i[31:10]) begin
        e_hit = 1; e_mask = m_mask[k]; e_val = m_val[k]; e_ptr = m_ptr[k];
      end
      if (up_valid_i) begin
        k = int'(up_addr_i[9:0]);
        if (up_mask_i != 0) begin
          m_tag[k] = up_addr_i[31:10]; m_mask[k] = up_mask_i;
          m_ptr[k] = up_ptr_i; m_val[k] = up_val_i;
        end else if (m_tag.exists(k)) begin
          m_tag.delete(k); m_mask.delete(k); m_ptr.delete(k); m_val.delete(k);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk(rsp_valid_o === e_v, "R2", "rsp_valid", 64'(rsp_valid_o), 64'(e_v));
      if (e_v) begin
        chk(rsp_hit_o === e_hit, phase, "hit", 64'(rsp_hit_o), 64'(e_hit));
        chk(rsp_mask_o === e_mask && rsp_val_o === e_val, {phase, " R10 R5"},
            "mask/val", {rsp_mask_o, rsp_val_o}, {e_mask, e_val});
        chk(rsp_ptr_o === e_ptr, {phase, " R10 R5"}, "ptr", 64'(rsp_ptr_o), 64'(e_ptr));
      end
    end
  end

  function automatic logic [AW-1:0] mk(input int tag, input int idx, input int bank);
    return {22'(tag), 6'(idx), 4'(bank)};
  endfunction

  task automatic op(input bit lv, input logic [AW-1:0] la, input bit uv,
                    input logic [AW-1:0] ua, input logic [NP-1:0] um,
                    input logic [NP*PW-1:0] up, input logic [NP-1:0] uval);
    @(negedge clk_i);
    lk_valid_i = lv; lk_addr_i = la;
    up_valid_i = uv; up_addr_i = ua; up_mask_i = um; up_ptr_i = up; up_val_i = uval;
  endtask

  task automatic lk(input logic [AW-1:0] a);
    op(1, a, 0, '0, '0, '0, '0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NP-1:0] m,
                    input logic [NP*PW-1:0] p, input logic [NP-1:0] v);
    op(0, '0, 1, a, m, p, v);
  endtask

  task automatic idle();
    op(0, '0, 0, '0, '0, '0, '0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1 rst_ni = 1'b0;
    #30;
    // R1: reset state
    chk(rsp_valid_o === 1'b0 && rsp_hit_o === 1'b0, "R1", "reset outputs",
        {rsp_valid_o, rsp_hit_o}, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    phase = "R1";
    lk(mk(0, 0, 0)); lk(mk(5, 63, 15)); lk(mk(1, 7, 3)); idle();

    // R4/R10: fill then hit, distinct pointer slots
    phase = "R4";
    wr(mk(3, 5, 2), 4'b1011, {9'd511, 9'd0, 9'd257, 9'd1}, 4'b1001);
    lk(mk(3, 5, 2)); idle(); lk(mk(3, 5, 2)); idle();

    // R3: neighbours differing in one tag bit / index bit / bank bit miss
    phase = "R3";
    lk(mk(3 | (1 << 21), 5, 2)); lk(mk(3, 4, 2)); lk(mk(3, 5, 3)); lk(mk(2, 5, 2)); idle();

    // R9: same index, different banks coexist
    phase = "R9";
    wr(mk(9, 5, 7), 4'b0001, {27'd0, 9'd100}, 4'b0001);
    wr(mk(10, 5, 15), 4'b1111, {9'd1, 9'd2, 9'd3, 9'd4}, 4'b0110);
    lk(mk(9, 5, 7)); lk(mk(10, 5, 15)); lk(mk(3, 5, 2)); idle();

    // R6: overwrite occupied slot with other tag
    phase = "R6";
    wr(mk(4, 5, 2), 4'b0100, {9'd0, 9'd300, 18'd0}, 4'b0100);
    lk(mk(3, 5, 2)); lk(mk(4, 5, 2)); idle();

    // R7: zero mask empties slot
    phase = "R7";
    wr(mk(4, 5, 2), 4'b0000, '0, '0);
    lk(mk(4, 5, 2)); lk(mk(9, 5, 7)); idle();

    // R8: same-cycle lookup and update on one slot
    phase = "R8";
    op(1, mk(9, 5, 7), 1, mk(11, 5, 7), 4'b0011, {18'd0, 9'd50, 9'd60}, 4'b0010);
    lk(mk(9, 5, 7)); lk(mk(11, 5, 7));
    op(1, mk(11, 5, 7), 1, mk(11, 5, 7), 4'b0000, '0, '0);
    lk(mk(11, 5, 7));
    op(1, mk(12, 1, 1), 1, mk(12, 1, 1), 4'b1000, {9'd77, 27'd0}, 4'b1000);
    lk(mk(12, 1, 1)); idle();

    // R10: random mix over a small address pool
    phase = "R10";
    for (int i = 0; i < 3000; i++) begin
      logic [NP-1:0] m;
      m = ($urandom_range(0, 4) == 0) ? '0 : NP'($urandom);
      op($urandom_range(0, 1) == 1, mk($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3)),
         $urandom_range(0, 2) == 0, mk($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3)),
         m, {$urandom, $urandom}, NP'($urandom));
    end
    idle(); idle(); idle();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule